// File: doc/BRIEF.md
# Two-Step Refresh Watchdog Counter

This block is a supervision counter for a small processor. After software starts it, a 15-bit count climbs at a rate derived from the machine-cycle enable. If software lets the count reach all ones, the block raises an internal reset request and latches a status flag. To keep it quiet, software must write the arm bit and then the start bit within a short window of machine cycles. A lone start write does nothing to a running counter. Nothing but an external reset can stop the counter once it is running.

One 8-bit register sets both the reload value and the rate. Its top bit chooses a slow count rate; its lower seven bits give the upper part of the counter on start, refresh and wrap. While the counter is stopped, the upper byte of the counter follows every write of that register, and the lower byte stays at zero. The host bus, the CPU core and the clock division that makes the machine cycle all sit outside this block. Register writes arrive as single-clock strobes.

Top module: `wdog_twostep`

## Requirements
- R1: After external reset the counter reads 0x00 in both bytes, the reset request and the status flag are low, the reload register holds 0x00 and the counter is stopped.
- R2: While stopped, a reload write sets the high byte on the next clock to {0, wdata[6:0]}. Bit 7 of the write never appears there. The low byte reads 0x00 for the whole stopped time.
- R3: A start write while stopped loads {reload[6:0], 0x00} into the counter and begins counting.
- R4: The running counter advances by one every 2 enabled machine cycles when reload bit 7 is 0, and every 128 when it is 1. Clocks without the machine-cycle enable do not count.
- R5: While running, a start write that has no live arm window has no effect on the count.
- R6: An arm write opens a window of 3 enabled machine cycles. A start write inside the window reloads {reload[6:0], 0x00} and restarts the rate divider from phase zero. A start write after the window has no effect.
- R7: Once running, the counter never stops except on external reset. Reload writes while running leave the count untouched.
- R8: The reset request is high exactly while the running count is 0x7FFF, so it lasts one rate period. The count then wraps to {reload[6:0], 0x00} and keeps counting.
- R9: The status flag is set on the clock after any cycle with the reset request high and stays set until a clear write. A set in the same cycle as a clear wins.
- R10: An external reset at any time stops the counter and clears the count, the reload register and the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| cyc_en | input | 1 | Machine-cycle enable, one clock per machine cycle |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | 8 | Reload write data: bit 7 selects slow rate, bits 6..0 the high reload value |
| arm_we | input | 1 | Arm-bit write strobe, opens the refresh window |
| start_we | input | 1 | Start-bit write strobe: starts when stopped, refreshes when armed |
| flag_clr_we | input | 1 | Status-flag clear strobe |
| wd_rst | output | 1 | Internal reset request |
| wd_flag | output | 1 | Sticky flag: a watchdog reset has occurred |
| cnt_hi | output | 8 | Counter high byte, zero-extended |
| cnt_lo | output | 8 | Counter low byte |

## Verification
The assertions check on every cycle that the counter never leaves the running state, that the low byte is zero while stopped, and that the reset request appears only at the all-ones count. They also check that the flag follows the request, that an armed start clears the low byte, that the arm window closes after its enabled cycles, and that the count wraps to the reload value. Only the bench's scenarios can show the exact count rate for both settings and that a lone or late start write is ignored. They also show the exact cycle when the reset request rises and falls, that a set beats a simultaneous clear, and that an external reset in mid-run returns everything to zero. A cycle-level model in the bench follows random write traffic against all four outputs.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   typedef enum logic {
      WD_STOPPED = 1'b0,
      WD_RUNNING = 1'b1
   } wd_state_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int FAST_DIV = 2,
   parameter int SLOW_DIV = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic cyc_en,
   input  logic slow,
   output logic tick
);
   localparam int PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
   localparam logic [PW-1:0] SLOW_LIM = PW'(SLOW_DIV - 1);

   if (FAST_DIV < 1 || SLOW_DIV < FAST_DIV) begin : g_bad_div
      $error("wdog_prescaler: need 1 <= FAST_DIV <= SLOW_DIV");
   end

   logic [PW-1:0] pre_q;
   logic          fast_hit;
   logic          slow_hit;

   if (FAST_DIV == 1) begin : g_fast_direct
      assign fast_hit = 1'b1;
   end else begin : g_fast_cmp
      localparam logic [PW-1:0] FAST_LIM = PW'(FAST_DIV - 1);
      assign fast_hit = (pre_q == FAST_LIM);
   end

   assign slow_hit = (pre_q == SLOW_LIM);
   assign tick     = cyc_en && (slow ? slow_hit : fast_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (clr)     pre_q <= '0;
      else if (tick)    pre_q <= '0;
      else if (cyc_en)  pre_q <= pre_q + 1'b1;
   end

   // R6
   phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !tick || (FAST_DIV == 1));
endmodule

// File: rtl/wdog_arm_window.sv
module wdog_arm_window #(
   parameter int WIN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_en,
   input  logic arm_set,
   input  logic consume,
   output logic live
);
   localparam int AW = $clog2(WIN + 1);

   if (WIN < 1) begin : g_bad_win
      $error("wdog_arm_window: WIN must be at least 1");
   end

   logic [AW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          left_q <= '0;
      else if (arm_set)                    left_q <= AW'(WIN);
      else if (consume)                    left_q <= '0;
      else if (cyc_en && left_q != '0)     left_q <= left_q - 1'b1;
   end

   assign live = (left_q != '0);

   // R6
   arm_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_en && !arm_set && left_q == AW'(1)) |=> !live);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             running,
   input  logic             load,
   input  logic [CNT_W-9:0] load_val,
   input  logic             preset,
   input  logic [CNT_W-9:0] preset_val,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             at_max
);
   logic [CNT_W-1:0] cnt_q;

   assign at_max = &cnt_q;
   assign cnt    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load)                   cnt_q <= {load_val, 8'h00};
      else if (!running && preset)     cnt_q <= {preset_val, 8'h00};
      else if (running && tick)        cnt_q <= at_max ? {load_val, 8'h00} : cnt_q + 1'b1;
   end

   // R2
   lo_zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (cnt_q[7:0] == 8'h00));

   // R8
   wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick && at_max && !load) |=> (cnt_q == {$past(load_val), 8'h00}));
endmodule

// File: rtl/wdog_twostep.sv
module wdog_twostep #(
   parameter int CNT_W    = 15,
   parameter int FAST_DIV = 2,
   parameter int SLOW_DIV = 128,
   parameter int ARM_WIN  = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cyc_en,
   input  logic       reload_we,
   input  logic [7:0] reload_wdata,
   input  logic       arm_we,
   input  logic       start_we,
   input  logic       flag_clr_we,
   output logic       wd_rst,
   output logic       wd_flag,
   output logic [7:0] cnt_hi,
   output logic [7:0] cnt_lo
);
   import wdog_pkg::*;

   localparam int HIW = CNT_W - 8;

   if (CNT_W < 9 || CNT_W > 15) begin : g_bad_width
      $error("wdog_twostep: CNT_W must lie in 9..15");
   end

   logic [7:0]       reload_q;
   wd_state_e        state_q;
   logic             running;
   logic             arm_live;
   logic             refresh;
   logic             tick;
   logic             at_max;
   logic             flag_q;
   logic [CNT_W-1:0] cnt;

   assign running = (state_q == WD_RUNNING);
   assign refresh = start_we && (!running || arm_live);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= 8'h00;
         state_q  <= WD_STOPPED;
         flag_q   <= 1'b0;
      end else begin
         if (reload_we) reload_q <= reload_wdata;
         if (start_we)  state_q  <= WD_RUNNING;
         flag_q <= (flag_q && !flag_clr_we) || wd_rst;
      end
   end

   wdog_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (refresh || !running),
      .cyc_en (cyc_en),
      .slow   (reload_q[7]),
      .tick   (tick)
   );

   wdog_arm_window #(.WIN(ARM_WIN)) u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .cyc_en  (cyc_en),
      .arm_set (arm_we),
      .consume (refresh),
      .live    (arm_live)
   );

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .running    (running),
      .load       (refresh),
      .load_val   (reload_q[HIW-1:0]),
      .preset     (reload_we),
      .preset_val (reload_wdata[HIW-1:0]),
      .tick       (tick),
      .cnt        (cnt),
      .at_max     (at_max)
   );

   assign wd_rst  = running && at_max;
   assign wd_flag = flag_q;
   assign cnt_hi  = 8'({cnt[CNT_W-1:8]});
   assign cnt_lo  = cnt[7:0];

   // R7
   run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> running);

   // R8
   rst_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst |-> (cnt_lo == 8'hFF));

   // R9
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst |=> wd_flag);

   // R6
   armed_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_we && arm_live) |=> (cnt_lo == 8'h00));
endmodule

// File: tb/sim_wdog_twostep.sv
module sim_wdog_twostep;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_en = 1'b0;
   logic       reload_we = 1'b0;
   logic [7:0] reload_wdata = 8'h00;
   logic       arm_we = 1'b0;
   logic       start_we = 1'b0;
   logic       flag_clr_we = 1'b0;
   logic       wd_rst;
   logic       wd_flag;
   logic [7:0] cnt_hi;
   logic [7:0] cnt_lo;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state
   logic        m_run;
   logic [14:0] m_cnt;
   logic [6:0]  m_pre;
   logic [1:0]  m_arm;
   logic        m_flag;
   logic [7:0]  m_rel;

   always #5 clk = ~clk;

   wdog_twostep u0 (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .reload_we(reload_we),
      .reload_wdata(reload_wdata), .arm_we(arm_we), .start_we(start_we),
      .flag_clr_we(flag_clr_we), .wd_rst(wd_rst), .wd_flag(wd_flag),
      .cnt_hi(cnt_hi), .cnt_lo(cnt_lo)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic ref_reset();
      m_run = 0; m_cnt = '0; m_pre = '0; m_arm = '0; m_flag = 0; m_rel = 8'h00;
   endtask

   task automatic ref_step(input bit en, input bit rwe, input logic [7:0] rd,
                           input bit arm, input bit st, input bit clr);
      bit        live, refresh, hit;
      logic [6:0] lim;
      live    = (m_arm != 0);
      refresh = st && (!m_run || live);
      m_flag  = (m_flag && !clr) || (m_run && m_cnt == 15'h7FFF);
      if (arm)                    m_arm = 2'd3;
      else if (refresh)           m_arm = 2'd0;
      else if (en && m_arm != 0)  m_arm = m_arm - 2'd1;
      if (refresh) begin
         m_cnt = {m_rel[6:0], 8'h00};
         m_pre = '0;
         m_run = 1;
      end else if (!m_run) begin
         if (rwe) m_cnt = {rd[6:0], 8'h00};
      end else if (en) begin
         lim = m_rel[7] ? 7'd127 : 7'd1;
         hit = (m_pre == lim);
         if (hit) begin
            m_pre = '0;
            m_cnt = (m_cnt == 15'h7FFF) ? {m_rel[6:0], 8'h00} : m_cnt + 15'd1;
         end else begin
            m_pre = m_pre + 7'd1;
         end
      end
      if (rwe) m_rel = rd;
   endtask

   task automatic compare_model();
      chk("R4", "cnt_hi vs model", cnt_hi, {1'b0, m_cnt[14:8]});
      chk("R4", "cnt_lo vs model", cnt_lo, m_cnt[7:0]);
      chk("R8", "wd_rst vs model", wd_rst, (m_run && m_cnt == 15'h7FFF));
      chk("R9", "wd_flag vs model", wd_flag, m_flag);
   endtask

   task automatic cyc(input bit en, input bit rwe = 0, input logic [7:0] rd = 8'h00,
                      input bit arm = 0, input bit st = 0, input bit clr = 0);
      @(negedge clk);
      cyc_en = en; reload_we = rwe; reload_wdata = rd;
      arm_we = arm; start_we = st; flag_clr_we = clr;
      @(posedge clk);
      ref_step(en, rwe, rd, arm, st, clr);
      #1;
      compare_model();
   endtask

   task automatic ext_reset();
      @(negedge clk);
      rst_n = 0; cyc_en = 0; reload_we = 0; arm_we = 0; start_we = 0; flag_clr_we = 0;
      ref_reset();
      @(posedge clk);
      #1;
      compare_model();
      @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      for (int i = 0; i < 150000; i++) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'd12345;
      void'($urandom(seed));
      ext_reset();
      // R1 reset state
      chk("R1", "hi after reset", cnt_hi, 8'h00);
      chk("R1", "lo after reset", cnt_lo, 8'h00);
      chk("R1", "wd_rst after reset", wd_rst, 0);
      chk("R1", "flag after reset", wd_flag, 0);

      // R2 stopped reload write
      cyc(0, 1, 8'h7F);
      chk("R2", "hi follows reload while stopped", cnt_hi, 8'h7F);
      for (int i = 0; i < 5; i++) cyc(1);
      chk("R2", "lo zero while stopped", cnt_lo, 8'h00);
      chk("R2", "hi held while stopped", cnt_hi, 8'h7F);

      // R3 start
      cyc(0, 0, 8'h00, 0, 1);
      chk("R3", "hi after start", cnt_hi, 8'h7F);
      chk("R3", "lo after start", cnt_lo, 8'h00);
      // R4 fast rate and enable gating
      cyc(1); cyc(1);
      chk("R4", "lo after 2 enabled cycles", cnt_lo, 8'h01);
      cyc(0); cyc(0); cyc(0);
      chk("R4", "lo held without enable", cnt_lo, 8'h01);

      // R5 lone start ignored
      cyc(1);
      cyc(0, 0, 8'h00, 0, 1);
      cyc(1);
      chk("R5", "lone start ignored", cnt_lo, 8'h02);

      // R6 late start after window ignored
      cyc(0, 0, 8'h00, 1);
      cyc(1); cyc(1); cyc(1);
      cyc(0, 0, 8'h00, 0, 1);
      chk("R6", "late start ignored", cnt_lo, 8'h03);

      // R6 armed refresh
      cyc(0, 0, 8'h00, 1);
      cyc(1); cyc(1);
      cyc(0, 0, 8'h00, 0, 1);
      chk("R6", "refresh hi", cnt_hi, 8'h7F);
      chk("R6", "refresh lo", cnt_lo, 8'h00);
      cyc(1);
      chk("R6", "divider phase cleared", cnt_lo, 8'h00);
      cyc(1);
      chk("R6", "first tick after refresh", cnt_lo, 8'h01);

      // R8 timeout pulse
      for (int i = 0; i < 507; i++) cyc(1);
      chk("R8", "no reset before max", wd_rst, 0);
      chk("R8", "lo just below max", cnt_lo, 8'hFE);
      cyc(1);
      chk("R8", "reset at 7FFF", wd_rst, 1);
      chk("R9", "flag lags request", wd_flag, 0);
      cyc(1);
      chk("R8", "reset held for rate period", wd_rst, 1);
      chk("R9", "flag set", wd_flag, 1);
      cyc(1);
      chk("R8", "reset ends", wd_rst, 0);
      chk("R8", "wrapped to reload", {cnt_hi, cnt_lo}, 16'h7F00);
      chk("R9", "flag sticky", wd_flag, 1);

      // R7 reload write while running
      cyc(0, 1, 8'h10);
      chk("R7", "running count untouched by reload write", {cnt_hi, cnt_lo}, 16'h7F00);
      cyc(1); cyc(1);
      chk("R7", "still counting", cnt_lo, 8'h01);

      // R9 clear
      cyc(0, 0, 8'h00, 0, 0, 1);
      chk("R9", "flag cleared", wd_flag, 0);

      // R10 external reset mid-run
      ext_reset();
      chk("R10", "count cleared", {cnt_hi, cnt_lo}, 16'h0000);
      chk("R10", "flag cleared", wd_flag, 0);
      for (int i = 0; i < 4; i++) cyc(1);
      chk("R10", "stopped after reset", cnt_lo, 8'h00);

      // R4 slow rate
      cyc(0, 1, 8'hFF);
      chk("R2", "bit 7 not shown in hi", cnt_hi, 8'h7F);
      cyc(0, 0, 8'h00, 0, 1);
      for (int i = 0; i < 127; i++) cyc(1);
      chk("R4", "slow rate no tick at 127", cnt_lo, 8'h00);
      cyc(1);
      chk("R4", "slow rate tick at 128", cnt_lo, 8'h01);

      // R9 set beats clear
      ext_reset();
      cyc(0, 1, 8'h7F);
      cyc(0, 0, 8'h00, 0, 1);
      for (int i = 0; i < 510; i++) cyc(1);
      chk("R8", "reset at max again", wd_rst, 1);
      cyc(0, 0, 8'h00, 0, 0, 1);
      chk("R9", "set wins over clear", wd_flag, 1);

      // random traffic against model
      ext_reset();
      cyc(0, 1, {1'b0, 5'b11111, 2'($urandom)});
      cyc(0, 0, 8'h00, 0, 1);
      for (int i = 0; i < 3000; i++) begin
         bit en, rwe, arm, st, clr;
         logic [7:0] rd;
         en  = ($urandom % 4) != 0;
         rwe = ($urandom % 50) == 0;
         arm = ($urandom % 20) == 0;
         st  = ($urandom % 20) == 0;
         clr = ($urandom % 30) == 0;
         rd  = {(($urandom % 8) == 0), 5'b11111, 2'($urandom)};
         cyc(en, rwe, rd, arm, st, clr);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule